// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

The block holds two independent 32-bit down-counters behind a small synchronous register bus. Each counter counts down on qualified ticks. A tick comes from one of two sources. The first is the main clock divided by a power of two. The second is an externally supplied reference tick enable. When a counter is at zero and receives a tick, it raises an event bit in a shared status register. It then either reloads from its reload register or stops (one-shot).

Software uses the block in three ways:
- **Free-running time base:** load all ones, enable reload, and read the elapsed count as the inverse of the live value.
- **Periodic interrupt:** load the reload and value registers with P-1 to get an event every P ticks.
- **One-shot deadline:** write a value and enable the channel without reload.

The interrupt output is high while any status bit is set. Software clears a status bit by writing zero to it.

Top module: `duo_timer`

## Requirements
- R1: After synchronous reset, every register reads zero and `irq` is low.
- R2: Register offsets (byte addresses) are:
  - control at 0x00;
  - status at 0x04, with channel 0 in bit 0 and channel 1 in bit 8;
  - channel 0 reload at 0x10 and value at 0x14;
  - channel 1 reload at 0x18 and value at 0x1C.
  
  Control bit positions are:
  - channel 0: enable bit 0, reload-enable bit 1, reference select bit 11, divider field bits 21:19;
  - channel 1: enable bit 2, reload-enable bit 3, reference select bit 12, divider field bits 24:22.
  
  Other control bits and unmapped offsets read as zero.
- R3: A disabled channel holds its value. With its reference select bit set, an enabled channel decrements only in cycles where `ref_tick` is high.
- R4: With reference select clear and divider field N, an enabled channel decrements once every 2^N clocks. The first decrement lands 2^N clocks after the enabling write. The divider restarts from zero whenever the channel is disabled.
- R5: A tick arriving while the count is zero sets the channel's status bit. If reload is enabled, the count is then loaded from the channel's reload register.
- R6: With reload disabled, an expiry leaves the count at zero and clears the channel's enable bit, unless a control write lands in the same cycle.
- R7: Writing a 0 to a status bit clears it, and writing a 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R8: A write to a value register takes effect at the next clock edge. It overrides any decrement or expiry in that cycle. Reads return the live count.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: With reload and value both set to P-1 and reload enabled, events occur every P ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, one clock wide per tick |
| bus_addr | input | ADDR_W (5) | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, OR of the status bits |

## Verification
Assertions check several rules on every cycle:
- per-cycle counter behaviour: holding without a tick, reload on expiry, one-shot stop, and write override;
- the one-shot clearing of the enable bit;
- the precedence of an expiry over a status clear;
- that consecutive prescaled ticks never fire back to back when the divider is nonzero.

Only the bench scenarios can show the following:
- absolute timing, meaning the exact clock on which an event appears for a given value, divider and source;
- the register map as seen from the bus;
- the periodic cadence measured across several events;
- that a channel using the reference tick ignores long stretches without one.

// File: rtl/duo_timer_pkg.sv
package duo_timer_pkg;

    localparam int NCH    = 2;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 3;

    localparam int CTRL_OFF = 'h00;
    localparam int STAT_OFF = 'h04;

    typedef struct packed {
        logic             run;
        logic             auto_reload;
        logic             use_ref;
        logic [DIV_W-1:0] div_sel;
    } chan_cfg_t;

    function automatic int run_bit(int ch);
        return 2 * ch;
    endfunction

    function automatic int reload_bit(int ch);
        return 2 * ch + 1;
    endfunction

    function automatic int ref_bit(int ch);
        return 11 + ch;
    endfunction

    function automatic int div_lsb(int ch);
        return 19 + DIV_W * ch;
    endfunction

    function automatic int stat_bit(int ch);
        return 8 * ch;
    endfunction

    function automatic int reload_off(int ch);
        return 'h10 + 8 * ch;
    endfunction

    function automatic int value_off(int ch);
        return 'h14 + 8 * ch;
    endfunction

    function automatic chan_cfg_t cfg_from(logic [DATA_W-1:0] c, int ch);
        chan_cfg_t f;
        f.run         = c[run_bit(ch)];
        f.auto_reload = c[reload_bit(ch)];
        f.use_ref     = c[ref_bit(ch)];
        f.div_sel     = c[div_lsb(ch) +: DIV_W];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m[run_bit(ch)]    = 1'b1;
            m[reload_bit(ch)] = 1'b1;
            m[ref_bit(ch)]    = 1'b1;
            for (int b = 0; b < DIV_W; b++) begin
                m[div_lsb(ch) + b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/duo_timer_prescale.sv
module duo_timer_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             use_ref,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int SPAN_W = (1 << DIV_W) - 1;

    logic [SPAN_W-1:0] phase_q;
    logic [SPAN_W-1:0] mask;

    // mask has div_sel low bits set: the phase matches once every 2^div_sel cycles
    always_comb begin
        for (int i = 0; i < SPAN_W; i++) begin
            mask[i] = (i < int'(div_sel));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (use_ref ? ref_tick : ((phase_q & mask) == mask));

    // R4: a divided tick never follows another tick directly when the divider is nonzero
    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && !use_ref && div_sel != '0 && $past(run) && $past(!use_ref)
         && $stable(div_sel)) |-> !$past(tick));

endmodule

// File: rtl/duo_timer_counter.sv
module duo_timer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             auto_reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;

    assign at_zero = (count == '0);
    assign expire  = tick && at_zero && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (tick) begin
            if (at_zero) begin
                count <= auto_reload ? reload_val : '0;
            end else begin
                count <= count - 1'b1;
            end
        end
    end

    // R3: without tick or write the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> count == $past(count));

    // R5: expiry with reload enabled loads the reload value
    a_r5_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '0 && auto_reload && !wr_en) |=> count == $past(reload_val));

    // R6: one-shot expiry stays at zero
    a_r6_stay_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && count == '0 && !auto_reload && !wr_en) |=> count == '0);

    // R8: bus write wins over any decrement
    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> count == $past(wr_data));

endmodule

// File: rtl/duo_timer.sv
module duo_timer
    import duo_timer_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

    logic [DATA_W-1:0] ctrl_q;
    logic [NCH-1:0]    stat_q;
    logic [DATA_W-1:0] reload_q [NCH];
    logic [DATA_W-1:0] count_w  [NCH];
    logic              expire   [NCH];
    logic              tick_w   [NCH];
    logic              val_wr   [NCH];
    chan_cfg_t         cfg      [NCH];
    logic              ctrl_wr;
    logic              stat_wr;

    assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_OFF));
    assign stat_wr = bus_we && (bus_addr == ADDR_W'(STAT_OFF));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign cfg[c]    = cfg_from(ctrl_q, c);
        assign val_wr[c] = bus_we && (bus_addr == ADDR_W'(value_off(c)));

        duo_timer_prescale #(.DIV_W(DIV_W)) u_pre (
            .clk      (clk),
            .rst      (rst),
            .run      (cfg[c].run),
            .use_ref  (cfg[c].use_ref),
            .ref_tick (ref_tick),
            .div_sel  (cfg[c].div_sel),
            .tick     (tick_w[c])
        );

        duo_timer_counter #(.CNT_W(DATA_W)) u_cnt (
            .clk         (clk),
            .rst         (rst),
            .tick        (tick_w[c]),
            .auto_reload (cfg[c].auto_reload),
            .reload_val  (reload_q[c]),
            .wr_en       (val_wr[c]),
            .wr_data     (bus_wdata),
            .count       (count_w[c]),
            .expire      (expire[c])
        );

        // R6: one-shot expiry disarms the channel
        a_r6_disarm: assert property (@(posedge clk) disable iff (rst)
            (expire[c] && !cfg[c].auto_reload && !ctrl_wr) |=> !ctrl_q[run_bit(c)]);

        // R7: an expiry is never lost to a simultaneous clear
        a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
            expire[c] |=> stat_q[c]);

        // R7: writing one keeps a pending status bit
        a_r7_one_keeps: assert property (@(posedge clk) disable iff (rst)
            (stat_q[c] && stat_wr && bus_wdata[stat_bit(c)]) |=> stat_q[c]);
    end

    // control register: bus write first, otherwise one-shot disarm
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (expire[ch] && !cfg[ch].auto_reload) begin
                    ctrl_q[run_bit(ch)] <= 1'b0;
                end
            end
        end
    end

    // status bits: set on expiry, cleared by writing zero
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (expire[ch]) begin
                    stat_q[ch] <= 1'b1;
                end else if (stat_wr && !bus_wdata[stat_bit(ch)]) begin
                    stat_q[ch] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < NCH; ch++) reload_q[ch] <= '0;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                if (bus_we && bus_addr == ADDR_W'(reload_off(ch))) begin
                    reload_q[ch] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFF)) bus_rdata = ctrl_q;
        for (int ch = 0; ch < NCH; ch++) begin
            if (bus_addr == ADDR_W'(STAT_OFF))        bus_rdata[stat_bit(ch)] = stat_q[ch];
            if (bus_addr == ADDR_W'(reload_off(ch)))  bus_rdata = reload_q[ch];
            if (bus_addr == ADDR_W'(value_off(ch)))   bus_rdata = count_w[ch];
        end
    end

    assign irq = |stat_q;

    // R9: the request rises only out of an all-clear status
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(stat_q == '0));

endmodule

// File: tb/duo_timer_bench.sv
module duo_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    duo_timer u_duo_timer (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // write lands on the next edge; e returns that edge's cycle count
    task automatic wr(logic [4:0] a, logic [31:0] d, output int e);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        e = cyc;
    endtask

    task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // monitor: each rising interrupt must match the next expected cycle
    always @(negedge clk) begin
        if (!rst && irq && !irq_prev) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected irq", 32'(cyc), 32'hFFFF_FFFF);
            end else begin
                check("R5/R9 irq timing", 32'(cyc), 32'(exp_q.pop_front()));
            end
        end
        irq_prev <= irq;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int e, e2, d, p;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd("R1 ctrl", 5'h00, 32'h0);
        rd("R1 status", 5'h04, 32'h0);
        rd("R1 value0", 5'h14, 32'h0);
        rd("R1 reload1", 5'h18, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        // R2 map: control mask, unmapped offset, reload readback
        wr(5'h00, 32'hFFFF_FFFF, e);
        rd("R2 ctrl mask", 5'h00, 32'h01F8_180F);
        wr(5'h00, 32'h0, e);
        wr(5'h18, 32'hA5A5_1234, e);
        rd("R2 reload1", 5'h18, 32'hA5A5_1234);
        rd("R2 unmapped", 5'h08, 32'h0);
        wr(5'h18, 32'h0, e);

        // R6 one-shot channel 0, divider 0, value 5: event 6 edges after enable
        wr(5'h14, 32'd5, e);
        wr(5'h00, 32'h1, e);
        exp_q.push_back(e + 6);
        wait_to(e + 7);
        rd("R6 value stays zero", 5'h14, 32'h0);
        rd("R6 enable cleared", 5'h00, 32'h0);
        rd("R5 status bit0", 5'h04, 32'h1);

        // R7 writing ones keeps, writing zero clears; R9 irq follows
        wr(5'h04, 32'hFFFF_FFFF, e);
        rd("R7 ones keep", 5'h04, 32'h1);
        check("R9 irq high", 32'(irq), 32'h1);
        wr(5'h04, 32'hFFFF_FFFE, e);
        rd("R7 zero clears", 5'h04, 32'h0);
        check("R9 irq low", 32'(irq), 32'h0);

        // R10 periodic, P=4
        wr(5'h10, 32'd3, e);
        wr(5'h14, 32'd3, e);
        wr(5'h00, 32'h3, e);
        exp_q.push_back(e + 4);
        exp_q.push_back(e + 8);
        wait_to(e + 5);
        wr(5'h04, 32'hFFFF_FFFE, e2);
        wait_to(e + 9);
        rd("R10 periodic value", 5'h14, 32'd2);
        rd("R10 second event", 5'h04, 32'h1);
        wr(5'h00, 32'h0, e2);
        wr(5'h04, 32'hFFFF_FFFE, e2);

        // R8 value write overrides decrement; R3 disabled holds
        wr(5'h10, 32'd7, e);
        wr(5'h14, 32'd7, e);
        wr(5'h00, 32'h3, e);
        wr(5'h14, 32'd20, e2);
        rd("R8 write wins", 5'h14, 32'd20);
        wait_to(e2 + 3);
        rd("R8 live count", 5'h14, 32'd17);
        wr(5'h00, 32'h0, d);
        v = 32'd20 - 32'(d - e2);
        rd("R3 value at disable", 5'h14, v);
        wait_to(d + 5);
        rd("R3 disabled holds", 5'h14, v);

        // R4 channel 1, divider 2, value 2: decrements every 4, event at +12
        wr(5'h1C, 32'd2, e);
        wr(5'h00, 32'h0080_0004, e);
        exp_q.push_back(e + 12);
        wait_to(e + 5);
        rd("R4 first divided tick", 5'h1C, 32'd1);
        wait_to(e + 13);
        rd("R2 status bit8", 5'h04, 32'h100);
        rd("R6 ch1 enable cleared", 5'h00, 32'h0080_0000);
        rd("R3 ch0 untouched", 5'h14, v);
        wr(5'h04, 32'hFFFF_FEFF, e2);
        rd("R7 ch1 clear", 5'h04, 32'h0);

        // R3 reference tick source on channel 0
        wr(5'h14, 32'd1, e);
        wr(5'h00, 32'h0028_0801, e);
        wait_to(e + 40);
        rd("R3 no ref no count", 5'h14, 32'd1);
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
        rd("R3 ref decrement", 5'h14, 32'd0);
        @(negedge clk);
        p = cyc + 1;
        exp_q.push_back(p);
        ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
        rd("R5 ref expiry", 5'h04, 32'h1);
        rd("R6 ref disarm", 5'h00, 32'h0028_0800);

        repeat (3) @(negedge clk);
        check("R9 all events seen", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule